// File: doc/BRIEF.md
# Ambient Light Zone Tracker

The tracker receives one averaged light reading per averaging period, carried by a valid strobe. It places that reading in one of five brightness zones, which are separated by four boundaries. Every boundary has two thresholds, one for rising and one for falling. The gap between them gives hysteresis, so a reading that sits near a boundary does not make the zone toggle back and forth.

A two-bit policy input sets how a newly computed zone is applied:
- **Direct:** the zone follows every reading.
- **Up-only:** the zone may rise but never falls.
- **Delayed-down:** a rise is taken at once. A fall waits for a programmable run of consecutive readings that each call for a lower zone.

The tracker always outputs the current zone code and the matching entry of a five-entry target table. It also keeps a sticky changed flag that a status read clears. That flag drives an interrupt request when interrupts are enabled.

Top module: `als_zone_tracker`

## Requirements
- R1: After reset the zone code is 000, the changed flag and the interrupt are low, and the target output equals table entry 0.
- R2: Zones 0 to 3 are reported as codes 000 to 011 and zone 4 as code 100. The target output is always the table entry of the current zone, and entry z sits at bits [8z+7:8z] of the table port.
- R3: From zone z, the reading rises past boundary k (k >= z) only when it is strictly greater than that boundary's high threshold. Boundary k's high threshold sits at bits [8k+7:8k]. One reading may cross several boundaries in a row.
- R4: From zone z, the reading falls past boundary k (k < z) only when it is strictly less than that boundary's low threshold, at bits [8k+7:8k]. A reading between the thresholds leaves the zone unchanged. A rise is evaluated before a fall.
- R5: Policy 00 (direct) applies the computed zone on every valid reading. Without a valid strobe the zone holds.
- R6: Policy 01 (up-only) applies a higher computed zone and ignores a lower one.
- R7: Policy 1X (delayed-down) applies a higher zone at once. A lower zone is applied on the N-th consecutive valid reading that calls for a lower zone, where N = delay code + 6 (code 0 gives 6, code 31 gives 37). The zone applied is the one computed from that N-th reading.
- R8: Under delayed-down, any valid reading that does not call for a lower zone restarts the run of downward readings from zero.
- R9: The changed flag sets in the cycle after the zone changes. A status read clears it one cycle later. When a change and a read fall in the same cycle, the flag stays set.
- R10: The interrupt output equals the changed flag while the interrupt enable is high, and is low while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Averaged reading valid strobe |
| smp_avg | input | 8 | Averaged reading |
| bnd_hi | input | 32 | Rising thresholds, boundary k at [8k+7:8k] |
| bnd_lo | input | 32 | Falling thresholds, boundary k at [8k+7:8k] |
| policy | input | 2 | Update policy: 00 direct, 01 up-only, 1X delayed-down |
| dly_code | input | 5 | Down-delay code; run length is code + 6 |
| irq_en | input | 1 | Interrupt enable |
| tgt_tbl | input | 40 | Per-zone targets, zone z at [8z+7:8z] |
| stat_rd | input | 1 | Status read strobe, clears the changed flag |
| zone_code | output | 3 | Current zone code |
| zone_chg | output | 1 | Sticky zone-changed flag |
| irq | output | 1 | Interrupt request |
| tgt_out | output | 8 | Target value of the current zone |

## Verification
The bench keeps the default parameters: four boundaries, 8-bit readings and a 5-bit delay code. With these, every zone code is reached, including code 100, and so are threshold-equal readings at both edges of each hysteresis band. The bench drives delay codes 0, 2 and 31. Both the shortest run (6 readings) and the longest run (37 readings) are therefore exercised within a few dozen samples. The same is true of a run that is broken one sample short. A long random phase that changes policy, reads, enables and delay codes covers same-cycle change-and-read cases against the reference model.

// File: rtl/als_zone_pkg.sv
package als_zone_pkg;

  typedef enum logic [1:0] {
    POL_DIRECT = 2'b00,
    POL_UPONLY = 2'b01,
    POL_DELAY  = 2'b10
  } pol_e;

  // Policy field decode: both 1X codes select delayed-down.
  function automatic pol_e pol_decode(input logic [1:0] raw);
    if (raw[1])
      return POL_DELAY;
    else if (raw[0])
      return POL_UPONLY;
    else
      return POL_DIRECT;
  endfunction

  // Number of consecutive downward readings needed before a fall is taken.
  function automatic int unsigned dly_need(input int unsigned code, input int unsigned base);
    return code + base;
  endfunction

endpackage

// File: rtl/als_zone_hyst.sv
// Computes the candidate zone from the current zone and one reading.
// The rise is evaluated first; the fall is evaluated only when no rise applies.
module als_zone_hyst #(
  parameter int NUM_BND = 4,
  parameter int DATA_W  = 8,
  localparam int ZW     = $clog2(NUM_BND + 1)
) (
  input  logic [ZW-1:0]             cur_zone,
  input  logic [DATA_W-1:0]         avg,
  input  logic [NUM_BND*DATA_W-1:0] hi_flat,
  input  logic [NUM_BND*DATA_W-1:0] lo_flat,
  output logic [ZW-1:0]             cand,
  output logic                      up_req,
  output logic                      dn_req
);

  logic [DATA_W-1:0] hi_a [NUM_BND];
  logic [DATA_W-1:0] lo_a [NUM_BND];

  for (genvar k = 0; k < NUM_BND; k++) begin : g_unpack
    assign hi_a[k] = hi_flat[k*DATA_W +: DATA_W];
    assign lo_a[k] = lo_flat[k*DATA_W +: DATA_W];
  end

  // Walk upward from the current zone while each rising threshold is exceeded.
  function automatic logic [ZW-1:0] walk_up(input logic [ZW-1:0] z,
                                            input logic [DATA_W-1:0] v,
                                            input logic [DATA_W-1:0] hi [NUM_BND]);
    logic [ZW-1:0] r;
    logic          go;
    r  = z;
    go = 1'b1;
    for (int k = 0; k < NUM_BND; k++) begin
      if (go && (k >= int'(z))) begin
        if (v > hi[k]) r = ZW'(k + 1);
        else           go = 1'b0;
      end
    end
    return r;
  endfunction

  // Walk downward from the current zone while each falling threshold is undercut.
  function automatic logic [ZW-1:0] walk_dn(input logic [ZW-1:0] z,
                                            input logic [DATA_W-1:0] v,
                                            input logic [DATA_W-1:0] lo [NUM_BND]);
    logic [ZW-1:0] r;
    logic          go;
    r  = z;
    go = 1'b1;
    for (int k = NUM_BND - 1; k >= 0; k--) begin
      if (go && (k < int'(z))) begin
        if (v < lo[k]) r = ZW'(k);
        else           go = 1'b0;
      end
    end
    return r;
  endfunction

  logic [ZW-1:0] up_z, dn_z;

  always_comb begin
    up_z   = walk_up(cur_zone, avg, hi_a);
    dn_z   = walk_dn(cur_zone, avg, lo_a);
    up_req = (up_z != cur_zone);
    dn_req = !up_req && (dn_z != cur_zone);
    cand   = up_req ? up_z : dn_z;
  end

endmodule

// File: rtl/als_zone_policy.sv
// Holds the zone register and the delayed-down run counter.
module als_zone_policy
  import als_zone_pkg::*;
#(
  parameter int NUM_BND  = 4,
  parameter int DLY_W    = 5,
  parameter int DLY_BASE = 6,
  localparam int ZW      = $clog2(NUM_BND + 1),
  localparam int CW      = $clog2((1 << DLY_W) + DLY_BASE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ZW-1:0]    cand,
  input  logic             up_req,
  input  logic             dn_req,
  input  logic [1:0]       policy,
  input  logic [DLY_W-1:0] dly_code,
  output logic [ZW-1:0]    zone_q,
  output logic             zone_move,
  output logic [CW-1:0]    dn_cnt
);

  pol_e          pol;
  logic [CW-1:0] need;
  logic [CW-1:0] cnt_d;
  logic          take;

  assign pol  = pol_decode(policy);
  assign need = CW'(dly_need(int'(dly_code), DLY_BASE));

  always_comb begin
    take  = 1'b0;
    cnt_d = dn_cnt;
    if (smp_vld) begin
      cnt_d = '0;
      unique case (pol)
        POL_DIRECT: take = up_req || dn_req;
        POL_UPONLY: take = up_req;
        POL_DELAY: begin
          if (dn_req) begin
            if ((dn_cnt + 1'b1) >= need) take = 1'b1;
            else                         cnt_d = dn_cnt + 1'b1;
          end else begin
            take = up_req;
          end
        end
        default: take = 1'b0;
      endcase
    end
  end

  assign zone_move = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q <= '0;
      dn_cnt <= '0;
    end else begin
      dn_cnt <= cnt_d;
      if (take) zone_q <= cand;
    end
  end

endmodule

// File: rtl/als_zone_flag.sv
// Sticky changed flag and gated interrupt request.
module als_zone_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_ev,
  input  logic irq_en,
  output logic flag_q,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;   // a change wins over a same-cycle read
    else if (rd_ev)  flag_q <= 1'b0;
  end

  assign irq = flag_q & irq_en;

endmodule

// File: rtl/als_zone_tracker.sv
module als_zone_tracker #(
  parameter int NUM_BND  = 4,
  parameter int DATA_W   = 8,
  parameter int TGT_W    = 8,
  parameter int DLY_W    = 5,
  parameter int DLY_BASE = 6,
  localparam int NZ      = NUM_BND + 1,
  localparam int ZW      = $clog2(NZ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic [DATA_W-1:0]         smp_avg,
  input  logic [NUM_BND*DATA_W-1:0] bnd_hi,
  input  logic [NUM_BND*DATA_W-1:0] bnd_lo,
  input  logic [1:0]                policy,
  input  logic [DLY_W-1:0]          dly_code,
  input  logic                      irq_en,
  input  logic [NZ*TGT_W-1:0]       tgt_tbl,
  input  logic                      stat_rd,
  output logic [ZW-1:0]             zone_code,
  output logic                      zone_chg,
  output logic                      irq,
  output logic [TGT_W-1:0]          tgt_out
);

  localparam int CW = $clog2((1 << DLY_W) + DLY_BASE + 1);

  // Named internal events, visible to the bound checker.
  logic [ZW-1:0] cand;
  logic          up_req;
  logic          dn_req;
  logic          zone_move;
  logic [CW-1:0] dn_cnt;

  als_zone_hyst #(.NUM_BND(NUM_BND), .DATA_W(DATA_W)) hyst_i (
    .cur_zone (zone_code),
    .avg      (smp_avg),
    .hi_flat  (bnd_hi),
    .lo_flat  (bnd_lo),
    .cand     (cand),
    .up_req   (up_req),
    .dn_req   (dn_req)
  );

  als_zone_policy #(.NUM_BND(NUM_BND), .DLY_W(DLY_W), .DLY_BASE(DLY_BASE)) pol_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .cand      (cand),
    .up_req    (up_req),
    .dn_req    (dn_req),
    .policy    (policy),
    .dly_code  (dly_code),
    .zone_q    (zone_code),
    .zone_move (zone_move),
    .dn_cnt    (dn_cnt)
  );

  als_zone_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (zone_move),
    .rd_ev  (stat_rd),
    .irq_en (irq_en),
    .flag_q (zone_chg),
    .irq    (irq)
  );

  // Target table lookup.
  logic [TGT_W-1:0] tgt_a [NZ];
  for (genvar z = 0; z < NZ; z++) begin : g_tgt
    assign tgt_a[z] = tgt_tbl[z*TGT_W +: TGT_W];
  end

  always_comb begin
    tgt_out = tgt_a[0];
    for (int z = 0; z < NZ; z++)
      if (zone_code == ZW'(z)) tgt_out = tgt_a[z];
  end

endmodule

// File: rtl/als_zone_tracker_chk.sv
module als_zone_tracker_chk #(
  parameter int NUM_BND  = 4,
  parameter int DATA_W   = 8,
  parameter int DLY_W    = 5,
  parameter int DLY_BASE = 6,
  localparam int ZW      = $clog2(NUM_BND + 1),
  localparam int CW      = $clog2((1 << DLY_W) + DLY_BASE + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      smp_vld,
  input logic [DATA_W-1:0]         smp_avg,
  input logic [NUM_BND*DATA_W-1:0] bnd_hi,
  input logic [NUM_BND*DATA_W-1:0] bnd_lo,
  input logic [1:0]                policy,
  input logic                      irq_en,
  input logic                      stat_rd,
  input logic [ZW-1:0]             zone_code,
  input logic                      zone_chg,
  input logic                      irq,
  input logic                      zone_move,
  input logic                      dn_req,
  input logic [CW-1:0]             dn_cnt
);

  function automatic logic [DATA_W-1:0] thr_of(input logic [NUM_BND*DATA_W-1:0] f,
                                               input int idx);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_BND; k++)
      if (k == idx) r = f[k*DATA_W +: DATA_W];
    return r;
  endfunction

  AST_ZONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(zone_code) <= NUM_BND);  // R2

  AST_NO_RISE_AT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (int'(zone_code) < NUM_BND) && (smp_avg <= thr_of(bnd_hi, int'(zone_code)))
    |=> zone_code <= $past(zone_code));  // R3

  AST_NO_FALL_AT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (zone_code != '0) && (smp_avg >= thr_of(bnd_lo, int'(zone_code) - 1))
    |=> zone_code >= $past(zone_code));  // R4

  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(zone_code));  // R5

  AST_UPONLY_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (policy == 2'b01) |=> zone_code >= $past(zone_code));  // R6

  AST_DELAY_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && policy[1] && (dn_cnt == '0) |=> zone_code >= $past(zone_code));  // R7

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !dn_req |=> dn_cnt == '0);  // R8

  AST_CHG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    zone_move |=> zone_chg);  // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !zone_move |=> !zone_chg);  // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);  // R10

endmodule

bind als_zone_tracker als_zone_tracker_chk #(
  .NUM_BND(NUM_BND), .DATA_W(DATA_W), .DLY_W(DLY_W), .DLY_BASE(DLY_BASE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .smp_avg   (smp_avg),
  .bnd_hi    (bnd_hi),
  .bnd_lo    (bnd_lo),
  .policy    (policy),
  .irq_en    (irq_en),
  .stat_rd   (stat_rd),
  .zone_code (zone_code),
  .zone_chg  (zone_chg),
  .irq       (irq),
  .zone_move (zone_move),
  .dn_req    (dn_req),
  .dn_cnt    (dn_cnt)
);

// File: tb/als_zone_tracker_tb.sv
`timescale 1ns/1ps
module als_zone_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [7:0]  smp_avg = '0;
  logic [31:0] bnd_hi;
  logic [31:0] bnd_lo;
  logic [1:0]  policy = 2'b00;
  logic [4:0]  dly_code = '0;
  logic        irq_en = 1'b0;
  logic [39:0] tgt_tbl;
  logic        stat_rd = 1'b0;
  logic [2:0]  zone_code;
  logic        zone_chg;
  logic        irq;
  logic [7:0]  tgt_out;

  always #10 clk = ~clk;

  als_zone_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_avg(smp_avg),
    .bnd_hi(bnd_hi), .bnd_lo(bnd_lo), .policy(policy), .dly_code(dly_code),
    .irq_en(irq_en), .tgt_tbl(tgt_tbl), .stat_rd(stat_rd),
    .zone_code(zone_code), .zone_chg(zone_chg), .irq(irq), .tgt_out(tgt_out)
  );

  int hi_v [4] = '{40, 90, 140, 190};
  int lo_v [4] = '{30, 80, 130, 180};
  int tg_v [5] = '{11, 22, 33, 44, 55};

  initial begin
    for (int k = 0; k < 4; k++) begin
      bnd_hi[k*8 +: 8] = 8'(hi_v[k]);
      bnd_lo[k*8 +: 8] = 8'(lo_v[k]);
    end
    for (int z = 0; z < 5; z++) tgt_tbl[z*8 +: 8] = 8'(tg_v[z]);
  end

  int    n_run = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // Behavioural reference model, updated on each rising edge.
  int m_zone = 0;
  int m_run  = 0;
  int m_flag = 0;

  function automatic int ref_zone(int z, int v);
    int r;
    r = z;
    while (r < 4 && v > hi_v[r]) r++;
    if (r != z) return r;
    while (r > 0 && v < lo_v[r-1]) r--;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_zone = 0; m_run = 0; m_flag = 0;
    end else begin
      int c;
      bit moved;
      moved = 0;
      if (smp_vld) begin
        c = ref_zone(m_zone, int'(smp_avg));
        if (policy == 2'b00) begin
          moved = (c != m_zone); m_run = 0;
        end else if (policy == 2'b01) begin
          moved = (c > m_zone); m_run = 0;
        end else if (c < m_zone) begin
          if (m_run + 1 >= int'(dly_code) + 6) begin moved = 1; m_run = 0; end
          else m_run = m_run + 1;
        end else begin
          moved = (c > m_zone); m_run = 0;
        end
        if (moved) m_zone = c;
      end
      if (moved) m_flag = 1;
      else if (stat_rd) m_flag = 0;
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, int'(zone_code), m_zone, "zone");
      chk("R2", int'(tgt_out), tg_v[m_zone], "target");
      chk("R9", int'(zone_chg), m_flag, "flag");
      chk("R10", int'(irq), m_flag & int'(irq_en), "irq");
    end
  end

  task automatic sample(int v);
    @(negedge clk); #1;
    smp_vld = 1'b1; smp_avg = 8'(v);
    @(negedge clk); #1;
    smp_vld = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic read_status;
    @(negedge clk); #1; stat_rd = 1'b1;
    @(negedge clk); #1; stat_rd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    chk("R1", int'(zone_code), 0, "reset zone");
    chk("R1", int'(zone_chg), 0, "reset flag");
    chk("R1", int'(irq), 0, "reset irq");
    chk("R1", int'(tgt_out), 11, "reset target");

    cur_req = "R3";
    sample(40); chk("R3", int'(zone_code), 0, "equal to rising threshold");
    sample(41); chk("R3", int'(zone_code), 1, "one above rising threshold");
    sample(200); chk("R2", int'(zone_code), 4, "multi-boundary rise, code 100");
    chk("R2", int'(tgt_out), 55, "zone 4 target");

    cur_req = "R4";
    sample(130); chk("R4", int'(zone_code), 3, "fall stops at equal low");
    sample(85); chk("R4", int'(zone_code), 2, "fall one boundary");
    sample(139); chk("R4", int'(zone_code), 2, "inside band holds");

    cur_req = "R5";
    smp_avg = 8'd5; idle(4); chk("R5", int'(zone_code), 2, "no strobe holds");
    sample(5); chk("R5", int'(zone_code), 0, "direct fall");

    cur_req = "R9";
    chk("R9", int'(zone_chg), 1, "flag after change");
    read_status; chk("R9", int'(zone_chg), 0, "read clears");
    @(negedge clk); #1; smp_vld = 1'b1; smp_avg = 8'd100; stat_rd = 1'b1;
    @(negedge clk); #1; smp_vld = 1'b0; stat_rd = 1'b0;
    chk("R9", int'(zone_chg), 1, "change beats same-cycle read");

    cur_req = "R10";
    chk("R10", int'(irq), 0, "masked irq");
    irq_en = 1'b1; idle(1); chk("R10", int'(irq), 1, "enabled irq");
    read_status; chk("R10", int'(irq), 0, "irq drops after read");

    cur_req = "R6";
    policy = 2'b01;
    sample(10); chk("R6", int'(zone_code), 2, "up-only ignores fall");
    sample(250); chk("R6", int'(zone_code), 4, "up-only rise");

    cur_req = "R7";
    policy = 2'b10; dly_code = 5'd0;
    for (int i = 0; i < 5; i++) sample(10);
    chk("R7", int'(zone_code), 4, "five down readings hold");
    sample(100); chk("R7", int'(zone_code), 2, "sixth reading falls to its zone");
    sample(250); chk("R7", int'(zone_code), 4, "delayed mode rises at once");

    cur_req = "R8";
    policy = 2'b11; dly_code = 5'd2;
    for (int i = 0; i < 7; i++) sample(10);
    sample(185);
    for (int i = 0; i < 7; i++) sample(10);
    chk("R8", int'(zone_code), 4, "run restarted by holding reading");
    sample(10); chk("R8", int'(zone_code), 0, "eighth of new run falls");

    cur_req = "R7";
    policy = 2'b10; dly_code = 5'd31;
    sample(250);
    for (int i = 0; i < 36; i++) sample(10);
    chk("R7", int'(zone_code), 4, "code 31 holds for 36");
    sample(10); chk("R7", int'(zone_code), 0, "code 31 falls on 37th");

    cur_req = "R5";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      smp_vld = ($urandom_range(0, 2) != 0);
      smp_avg = 8'($urandom_range(0, 255));
      stat_rd = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 63) == 0) policy = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 63) == 0) dly_code = 5'($urandom_range(0, 2));
      if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
    end
    @(negedge clk); #1; smp_vld = 1'b0; stat_rd = 1'b0;
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule